// File: doc/BRIEF.md
# Trace Cache Lookup Array

This block holds instruction traces that a fill unit has already assembled and answers one lookup per fetch cycle. A lookup presents a fetch address and the branch predictor's direction bits. If a stored trace starts at that address and the directions of the branches inside it agree with the prediction, the whole trace goes to the instruction latch in a single cycle. The instruction cache is then not needed for that fetch. If no trace agrees, a miss flag tells the fetch path to fetch one basic block from the instruction cache instead.

A trace holds at most `N_SLOTS` instructions spread over at most `M_BR` basic blocks. Each line stores the instruction words together with the trace's identity: its start address, its branch count, one direction bit per branch, and its instruction count. The array is direct-mapped. The fill unit writes a finished trace with its identity through a single write port. A flush input invalidates every line at once.

Top module: `trace_cache`

## Requirements
- R1: After reset, `hit_o`, `miss_o`, `slot_mask_o` and `trace_o` are zero, and every line is invalid, so the first lookup to any address reports a miss.
- R2: A lookup hits only when the indexed line is valid, its stored start address equals `fetch_addr_i` in every bit, and the stored direction bits equal `pred_dir_i` at every position below the stored branch count. Bit i of the direction fields belongs to the i-th branch of the trace in program order.
- R3: Prediction bits at positions equal to or above the stored branch count do not affect the result. With a branch count of 0, any prediction hits.
- R4: On a hit, `slot_mask_o` bit k is 1 exactly for k below the stored instruction count. `trace_o[k*INSTR_W +: INSTR_W]` carries stored slot k for those slots and zero for the others.
- R5: A lookup is answered on the clock edge after `fetch_valid_i` is sampled. A miss gives `miss_o`=1 and `hit_o`=0, with `slot_mask_o` and `trace_o` zero.
- R6: In a cycle with `fetch_valid_i` low, both `hit_o` and `miss_o` are low on the next cycle.
- R7: A write overwrites the line selected by `wr_addr_i[IDX_LSB +: IDX_W]` and sets it valid. An older trace whose start address maps to the same line is evicted and then misses. The write inputs must satisfy 1 <= `wr_cnt_i` <= `N_SLOTS` and `wr_brc_i` <= `M_BR`.
- R8: `flush_i` invalidates all lines in one cycle. A write in the same cycle as a flush is discarded.
- R9: A lookup and a write (or flush) in the same cycle see the array contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| fetch_valid_i | input | 1 | Lookup request this cycle |
| fetch_addr_i | input | ADDR_W | Fetch address of the lookup |
| pred_dir_i | input | M_BR | Predicted branch directions, bit i for the i-th branch |
| wr_en_i | input | 1 | Write a finished trace |
| wr_addr_i | input | ADDR_W | Start address of the written trace |
| wr_brc_i | input | BRC_W | Number of branches in the written trace |
| wr_dir_i | input | M_BR | Direction bit of each branch in the written trace |
| wr_cnt_i | input | CNT_W | Number of instructions in the written trace |
| wr_trace_i | input | N_SLOTS*INSTR_W | Instruction words, slot k at bits k*INSTR_W |
| hit_o | output | 1 | A trace matched the lookup of the previous cycle |
| miss_o | output | 1 | No trace matched; fall back to the instruction cache |
| slot_mask_o | output | N_SLOTS | Valid instruction slots of the delivered trace |
| trace_o | output | N_SLOTS*INSTR_W | Delivered trace, masked to its valid slots |

## Verification
The assertions assume that a fill-unit write always carries a legal instruction count and branch count. One property checks this directly on the write port. The hit-after-fill property also assumes that the prediction repeats the written direction bits exactly. The bench keeps its stimulus inside these limits: counts are drawn from 1 to `N_SLOTS` and branch counts from 0 to `M_BR`. Fetch and write addresses come from a small pool of two tags per index, which makes hits, aliasing evictions and same-cycle write/lookup collisions frequent. Half of the predictions copy the stored direction bits of the target line, so both hits and direction mismatches occur often.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_MISS = 2'd1,
    LK_HIT  = 2'd2
  } lk_res_e;

  function automatic logic below(input int unsigned pos, input int unsigned lim);
    return pos < lim;
  endfunction
endpackage

// File: rtl/tc_meta_store.sv
module tc_meta_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned M_BR   = 3,
  parameter int unsigned BRC_W  = 2,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned LINES  = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BRC_W-1:0]  wr_brc_i,
  input  logic [M_BR-1:0]   wr_dir_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [BRC_W-1:0]  rd_brc_o,
  output logic [M_BR-1:0]   rd_dir_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  logic [LINES-1:0]  valid_q;
  logic [ADDR_W-1:0] addr_q [LINES];
  logic [BRC_W-1:0]  brc_q  [LINES];
  logic [M_BR-1:0]   dir_q  [LINES];
  logic [CNT_W-1:0]  cnt_q  [LINES];

  wire do_wr = wr_en_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         valid_q <= '0;
    else if (flush_i)    valid_q <= '0;
    else if (do_wr)      valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) begin
      addr_q[wr_idx_i] <= wr_addr_i;
      brc_q[wr_idx_i]  <= wr_brc_i;
      dir_q[wr_idx_i]  <= wr_dir_i;
      cnt_q[wr_idx_i]  <= wr_cnt_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_addr_o  = addr_q[rd_idx_i];
  assign rd_brc_o   = brc_q[rd_idx_i];
  assign rd_dir_o   = dir_q[rd_idx_i];
  assign rd_cnt_o   = cnt_q[rd_idx_i];
endmodule

// File: rtl/tc_data_store.sv
module tc_data_store #(
  parameter int unsigned LINE_W = 512,
  parameter int unsigned LINES  = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tc_hit_cmp.sv
module tc_hit_cmp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned M_BR   = 3,
  parameter int unsigned BRC_W  = 2
) (
  input  logic              line_valid_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic [BRC_W-1:0]  line_brc_i,
  input  logic [M_BR-1:0]   line_dir_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [M_BR-1:0]   pred_dir_i,
  output logic              match_o
);
  logic [M_BR-1:0] br_used;

  // only the branches contained in the trace take part
  for (genvar i = 0; i < M_BR; i++) begin : g_br
    assign br_used[i] = tc_pkg::below(i, 32'(line_brc_i));
  end

  wire dir_ok  = ((line_dir_i ^ pred_dir_i) & br_used) == '0;
  wire addr_ok = line_addr_i == fetch_addr_i;

  assign match_o = line_valid_i && addr_ok && dir_ok;
endmodule

// File: rtl/trace_cache.sv
module trace_cache #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned M_BR    = 3,
  parameter int unsigned LINES   = 8,
  parameter int unsigned IDX_LSB = 2,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned BRC_W  = $clog2(M_BR + 1),
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1),
  localparam int unsigned LINE_W = N_SLOTS * INSTR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               fetch_valid_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  input  logic [M_BR-1:0]    pred_dir_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BRC_W-1:0]   wr_brc_i,
  input  logic [M_BR-1:0]    wr_dir_i,
  input  logic [CNT_W-1:0]   wr_cnt_i,
  input  logic [LINE_W-1:0]  wr_trace_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic [N_SLOTS-1:0] slot_mask_o,
  output logic [LINE_W-1:0]  trace_o
);
  import tc_pkg::*;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              rd_valid, match;
  logic [ADDR_W-1:0] rd_addr;
  logic [BRC_W-1:0]  rd_brc;
  logic [M_BR-1:0]   rd_dir;
  logic [CNT_W-1:0]  rd_cnt;
  logic [LINE_W-1:0] rd_data, trace_d;
  logic [N_SLOTS-1:0] mask_d;
  lk_res_e           res_d, res_q;
  logic [N_SLOTS-1:0] mask_q;
  logic [LINE_W-1:0] trace_q;

  assign rd_idx = fetch_addr_i[IDX_LSB +: IDX_W];
  assign wr_idx = wr_addr_i[IDX_LSB +: IDX_W];

  tc_meta_store #(
    .ADDR_W(ADDR_W), .M_BR(M_BR), .BRC_W(BRC_W), .CNT_W(CNT_W), .LINES(LINES)
  ) i_meta (
    .clk_i, .rst_ni, .flush_i, .wr_en_i,
    .wr_idx_i(wr_idx), .wr_addr_i, .wr_brc_i, .wr_dir_i, .wr_cnt_i,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr),
    .rd_brc_o(rd_brc), .rd_dir_o(rd_dir), .rd_cnt_o(rd_cnt)
  );

  tc_data_store #(.LINE_W(LINE_W), .LINES(LINES)) i_data (
    .clk_i, .flush_i, .wr_en_i,
    .wr_idx_i(wr_idx), .wr_data_i(wr_trace_i),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  tc_hit_cmp #(.ADDR_W(ADDR_W), .M_BR(M_BR), .BRC_W(BRC_W)) i_cmp (
    .line_valid_i(rd_valid), .line_addr_i(rd_addr), .line_brc_i(rd_brc),
    .line_dir_i(rd_dir), .fetch_addr_i, .pred_dir_i, .match_o(match)
  );

  wire hit_d = fetch_valid_i && match;

  // deliver only the slots the trace fills; the rest read as zero
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign mask_d[k] = hit_d && below(k, 32'(rd_cnt));
    assign trace_d[k*INSTR_W +: INSTR_W] =
      rd_data[k*INSTR_W +: INSTR_W] & {INSTR_W{mask_d[k]}};
  end

  always_comb begin
    res_d = LK_IDLE;
    if (fetch_valid_i) res_d = match ? LK_HIT : LK_MISS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= LK_IDLE;
      mask_q  <= '0;
      trace_q <= '0;
    end else begin
      res_q   <= res_d;
      mask_q  <= mask_d;
      trace_q <= trace_d;
    end
  end

  assign hit_o       = res_q == LK_HIT;
  assign miss_o      = res_q == LK_MISS;
  assign slot_mask_o = mask_q;
  assign trace_o     = trace_q;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned M_BR    = 3,
  localparam int unsigned BRC_W  = $clog2(M_BR + 1),
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1),
  localparam int unsigned LINE_W = N_SLOTS * INSTR_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               fetch_valid_i,
  input logic [ADDR_W-1:0]  fetch_addr_i,
  input logic [M_BR-1:0]    pred_dir_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [BRC_W-1:0]   wr_brc_i,
  input logic [M_BR-1:0]    wr_dir_i,
  input logic [CNT_W-1:0]   wr_cnt_i,
  input logic               hit_o,
  input logic               miss_o,
  input logic [N_SLOTS-1:0] slot_mask_o,
  input logic [LINE_W-1:0]  trace_o
);
  localparam logic [N_SLOTS-1:0] ONE = {{(N_SLOTS-1){1'b0}}, 1'b1};

  p_wr_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_cnt_i != '0) && (32'(wr_cnt_i) <= N_SLOTS) && (32'(wr_brc_i) <= M_BR));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !hit_o && !miss_o);

  p_lookup_answered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> hit_o || miss_o);

  p_miss_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> slot_mask_o == '0 && trace_o == '0);

  p_mask_prefix_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> slot_mask_o[0] && (((slot_mask_o + ONE) & slot_mask_o) == '0));

  p_flush_invalidates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 fetch_valid_i |=> miss_o);

  p_fill_then_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) ##1
    (fetch_valid_i && fetch_addr_i == $past(wr_addr_i) && pred_dir_i == $past(wr_dir_i))
    |=> hit_o);
endmodule

bind trace_cache tc_checker #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .N_SLOTS(N_SLOTS), .M_BR(M_BR)
) i_tc_checker (
  .clk_i, .rst_ni, .flush_i, .fetch_valid_i, .fetch_addr_i, .pred_dir_i,
  .wr_en_i, .wr_addr_i, .wr_brc_i, .wr_dir_i, .wr_cnt_i,
  .hit_o, .miss_o, .slot_mask_o, .trace_o
);

// File: tb/test_trace_cache.sv
module test_trace_cache;
  localparam int unsigned AW = 32, IW = 32, NS = 16, MB = 3, LN = 8, IL = 2;
  localparam int unsigned BW = $clog2(MB + 1), CW = $clog2(NS + 1), LW = NS * IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, fv = 0, wr = 0;
  logic [AW-1:0] fa = '0, wa = '0;
  logic [MB-1:0] pd = '0, wd = '0;
  logic [BW-1:0] wb = '0;
  logic [CW-1:0] wc = '0;
  logic [LW-1:0] wt = '0;
  logic hit, miss;
  logic [NS-1:0] smask;
  logic [LW-1:0] trc;

  always #5 clk = ~clk;

  trace_cache #(.ADDR_W(AW), .INSTR_W(IW), .N_SLOTS(NS), .M_BR(MB), .LINES(LN), .IDX_LSB(IL))
  i_trace_cache (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .pred_dir_i(pd), .wr_en_i(wr), .wr_addr_i(wa), .wr_brc_i(wb), .wr_dir_i(wd),
    .wr_cnt_i(wc), .wr_trace_i(wt), .hit_o(hit), .miss_o(miss), .slot_mask_o(smask),
    .trace_o(trc)
  );

  // reference model
  logic          m_v [LN];
  logic [AW-1:0] m_a [LN];
  logic [BW-1:0] m_b [LN];
  logic [MB-1:0] m_d [LN];
  logic [CW-1:0] m_c [LN];
  logic [LW-1:0] m_t [LN];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int unsigned idx_of(input logic [AW-1:0] a);
    return int'(a[IL +: $clog2(LN)]);
  endfunction

  function automatic logic [LW-1:0] rnd_trace();
    logic [LW-1:0] t;
    for (int k = 0; k < NS; k++) t[k*IW +: IW] = $urandom;
    return t;
  endfunction

  task automatic cyc(input string tag);
    logic e_hit, e_miss;
    logic [NS-1:0] e_mask;
    logic [LW-1:0] e_tr;
    int unsigned i;
    logic dok;
    i = idx_of(fa);
    dok = 1'b1;
    for (int b = 0; b < MB; b++)
      if (b < int'(m_b[i]) && m_d[i][b] != pd[b]) dok = 1'b0;
    e_hit  = fv && m_v[i] && m_a[i] == fa && dok;
    e_miss = fv && !e_hit;
    e_mask = '0;
    e_tr   = '0;
    if (e_hit)
      for (int k = 0; k < int'(m_c[i]); k++) begin
        e_mask[k] = 1'b1;
        e_tr[k*IW +: IW] = m_t[i][k*IW +: IW];
      end
    if (flush) begin
      for (int l = 0; l < LN; l++) m_v[l] = 1'b0;
    end else if (wr) begin
      m_v[idx_of(wa)] = 1'b1; m_a[idx_of(wa)] = wa; m_b[idx_of(wa)] = wb;
      m_d[idx_of(wa)] = wd;   m_c[idx_of(wa)] = wc; m_t[idx_of(wa)] = wt;
    end
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (hit !== e_hit || miss !== e_miss || smask !== e_mask || trc !== e_tr) begin
      n_bad++;
      $display("FAIL %s: act hit=%b miss=%b mask=%h trace=%h exp hit=%b miss=%b mask=%h trace=%h",
               tag, hit, miss, smask, trc, e_hit, e_miss, e_mask, e_tr);
    end
    fv = 0; wr = 0; flush = 0;
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input int b, input logic [MB-1:0] d, input int c);
    wr = 1; wa = a; wb = BW'(b); wd = d; wc = CW'(c); wt = rnd_trace();
  endtask

  task automatic do_lk(input logic [AW-1:0] a, input logic [MB-1:0] p);
    fv = 1; fa = a; pd = p;
  endtask

  localparam logic [AW-1:0] A  = 32'h0000_1004;
  localparam logic [AW-1:0] AL = 32'h0000_2004;
  localparam logic [AW-1:0] B  = 32'h0000_1010;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int l = 0; l < LN; l++) begin
      m_v[l] = 0; m_a[l] = '0; m_b[l] = '0; m_d[l] = '0; m_c[l] = '0; m_t[l] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (hit !== 0 || miss !== 0 || smask !== '0 || trc !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: act hit=%b miss=%b mask=%h exp all zero", hit, miss, smask);
    end
    do_lk(A, 3'b000); cyc("R1 empty miss");
    do_lk(A, 3'b101); do_wr(A, 2, 3'b101, 5); cyc("R9 write+lookup sees old");
    do_lk(A, 3'b001); cyc("R3 bit above count ignored, R4 short trace");
    do_lk(A, 3'b011); cyc("R2 direction mismatch");
    do_lk(A ^ 32'h0001_0000, 3'b101); cyc("R2 start address mismatch");
    do_lk(A, 3'b101); do_wr(A, 3, 3'b110, 16); cyc("R9 old trace on overwrite");
    do_lk(A, 3'b110); cyc("R4 full trace");
    do_lk(A, 3'b010); cyc("R2 third branch mismatch");
    do_lk(AL, 3'b000); cyc("R2 alias miss");
    do_wr(AL, 0, 3'b000, 1); cyc("R6 idle during write");
    do_lk(A, 3'b110); cyc("R7 evicted");
    do_lk(AL, 3'b111); cyc("R3 zero branches any prediction");
    do_wr(B, 1, 3'b001, 7); cyc("R7 fill");
    do_lk(B, 3'b001); flush = 1; cyc("R9 lookup during flush");
    do_wr(A, 1, 3'b000, 3); flush = 1; cyc("R8 flush drops write");
    do_lk(A, 3'b000); cyc("R8 flushed write absent");
    do_lk(AL, 3'b111); cyc("R8 all lines invalid");
    do_lk(B, 3'b001); cyc("R8 all lines invalid");
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      a = {20'h00001, 7'(($urandom % 2) << 1), 3'($urandom % LN), 2'b00};
      if ($urandom % 10 < 8)
        do_lk(a, ($urandom % 2) ? m_d[idx_of(a)] : 3'($urandom));
      if ($urandom % 10 < 3) begin
        logic [AW-1:0] w;
        w = {20'h00001, 7'(($urandom % 2) << 1), 3'($urandom % LN), 2'b00};
        do_wr(w, int'($urandom % (MB + 1)), 3'($urandom), int'(1 + $urandom % NS));
      end
      if ($urandom % 50 == 0) flush = 1;
      cyc("R2/R4/R5/R7/R9 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule